// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps the interrupt status and interrupt enable state for a packet network controller and drives a single level-sensitive interrupt request. Event pulses from the packet allocator, the receive path and other sources set latched status bits. Software clears those bits by writing ones to an acknowledge register, and it picks the bits that may raise the interrupt through an enable (mask) register. Both registers can be read back through one read port.

Two of the bits are not plain latched events. The transmit-queue-empty bit and the transmit-done bit are set again from queue status inputs whenever their condition is true, so an acknowledge cannot keep them cleared. Acknowledging the transmit-done bit also sends a pop strobe to the transmit completion queue. The receive bit is set when a frame is stored. When the receive queue is popped, the bit is reloaded from whether entries remain in that queue.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x04 (only the transmit-empty bit set), the mask reads 0x00, and irq is low.
- R2: Status bit positions: 7 management, 6 early receive, 5 PHY event, 4 receive overrun, 3 allocation done, 2 transmit queue empty, 1 transmit done, 0 receive. A high ev_set[i] in a cycle sets status bit i at the next clock edge.
- R3: A write with wr_sel=0 is an acknowledge. It clears the written one-bits among bits 7, 6, 4, 2 and 1 (set 0xD6). Bits 5, 3 and 0 never change because of an acknowledge.
- R4: done_pop is high in exactly those cycles that carry an acknowledge write with wr_data bit 1 set.
- R5: In every cycle where txq_empty is high, status bit 2 is set at the next edge, even if the same cycle acknowledges it.
- R6: In every cycle where done_nonempty is high and done_pop is low, status bit 1 is set at the next edge. In a pop cycle the acknowledge can clear the bit, and it comes back in the next cycle if the queue still holds entries.
- R7: A cycle with rx_pop high loads status bit 0 with rx_more (1 = the receive queue still holds entries after the pop).
- R8: An event set has priority over an acknowledge clear and over a receive pop in the same cycle.
- R9: A write with wr_sel=1 loads the mask. rd_data shows the status when rd_sel=0 and the mask when rd_sel=1, with no clock edge needed.
- R10: irq is a register. It goes high one cycle after the AND of status and mask becomes nonzero, and low one cycle after that AND becomes zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 8 | Per-bit event set pulses |
| txq_empty | input | 1 | Transmit queue is empty (level) |
| done_nonempty | input | 1 | Transmit completion queue holds entries (level) |
| rx_pop | input | 1 | Receive queue pop in this cycle |
| rx_more | input | 1 | Receive queue still holds entries after the pop |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 acknowledge, 1 mask |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 status, 1 mask |
| rd_data | output | 8 | Read data |
| done_pop | output | 1 | Pop strobe to the completion queue |
| irq | output | 1 | Interrupt request, registered |

## Verification
The hardest case to reach is the transmit-done bit at the moment it is acknowledged while the completion queue is still reported non-empty. The bit has to drop for exactly one cycle and then come back, and a design that re-forces it in the pop cycle looks correct in every other test. The bench holds done_nonempty high across an acknowledge and then releases it right after a second acknowledge, so both the re-assert path and the stay-cleared path appear at the ports. Every acknowledge value from 0 to 255 is applied to a fully set status, and every mask value is swept against a changing status, with a bench-side model computing the expected status and irq.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int ST_W = 8;

  typedef enum logic {SEL_ACK = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  // Bits an acknowledge write is allowed to clear.
  function automatic logic [ST_W-1:0] ack_clear_bits(
    input logic [ST_W-1:0] wdata,
    input logic [ST_W-1:0] clearable
  );
    return wdata & clearable;
  endfunction

  // Interrupt condition: any enabled bit pending.
  function automatic logic any_pending(
    input logic [ST_W-1:0] st,
    input logic [ST_W-1:0] mk
  );
    return |(st & mk);
  endfunction
endpackage

// File: rtl/isc_wr_decode.sv
module isc_wr_decode
  import isc_pkg::*;
#(
  parameter logic [ST_W-1:0] ACK_CLEARABLE = 8'hD6,
  parameter int DONE_BIT = 1
) (
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [ST_W-1:0] wr_data,
  output logic            ack_stb,
  output logic            mask_stb,
  output logic [ST_W-1:0] clr_bits,
  output logic            done_pop
);
  reg_sel_e sel;
  assign sel      = reg_sel_e'(wr_sel);
  assign ack_stb  = wr_en && (sel == SEL_ACK);
  assign mask_stb = wr_en && (sel == SEL_MASK);
  assign clr_bits = ack_stb ? ack_clear_bits(wr_data, ACK_CLEARABLE) : '0;
  assign done_pop = ack_stb && wr_data[DONE_BIT];
endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg
  import isc_pkg::*;
#(
  parameter logic [ST_W-1:0] ACK_CLEARABLE = 8'hD6,
  parameter logic [ST_W-1:0] RESET_VALUE   = 8'h04,
  parameter int RX_BIT   = 0,
  parameter int DONE_BIT = 1,
  parameter int TXE_BIT  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] ev_set,
  input  logic [ST_W-1:0] clr_bits,
  input  logic            ack_stb,
  input  logic            done_pop,
  input  logic            txq_empty,
  input  logic            done_nonempty,
  input  logic            rx_pop,
  input  logic            rx_more,
  output logic [ST_W-1:0] status_q
);
  localparam logic [ST_W-1:0] LOCKED = ~ACK_CLEARABLE;

  logic [ST_W-1:0] status_d;

  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = status_q[b] & ~clr_bits[b];
      if (b == RX_BIT && rx_pop) nxt = rx_more;
      if (ev_set[b]) nxt = 1'b1;
      if (b == TXE_BIT && txq_empty) nxt = 1'b1;
      if (b == DONE_BIT && done_nonempty && !done_pop) nxt = 1'b1;
    end
    assign status_d[b] = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= RESET_VALUE;
    else        status_q <= status_d;
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(ev_set)) == $past(ev_set)));

  p_ack_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !rx_pop) |=>
      (((status_q & LOCKED) & $past(status_q & LOCKED)) == $past(status_q & LOCKED)));

  p_txe_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |=> status_q[TXE_BIT]);

  p_done_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_nonempty && !done_pop) |=> status_q[DONE_BIT]);

  p_rx_pop_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !ev_set[RX_BIT]) |=> (status_q[RX_BIT] == $past(rx_more)));
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg
  import isc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_stb,
  input  logic [ST_W-1:0] wr_data,
  output logic [ST_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= '0;
    else if (mask_stb) mask_q <= wr_data;
  end

  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_stb |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen
  import isc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] status_q,
  input  logic [ST_W-1:0] mask_q,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_pending(status_q, mask_q);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter logic [7:0] ACK_CLEARABLE = 8'hD6,
  parameter logic [7:0] RESET_VALUE   = 8'h04,
  parameter int RX_BIT   = 0,
  parameter int DONE_BIT = 1,
  parameter int TXE_BIT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ev_set,
  input  logic       txq_empty,
  input  logic       done_nonempty,
  input  logic       rx_pop,
  input  logic       rx_more,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       done_pop,
  output logic       irq
);
  logic            ack_stb;
  logic            mask_stb;
  logic [ST_W-1:0] clr_bits;
  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] mask_q;

  isc_wr_decode #(.ACK_CLEARABLE(ACK_CLEARABLE), .DONE_BIT(DONE_BIT)) u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_stb(ack_stb), .mask_stb(mask_stb), .clr_bits(clr_bits),
    .done_pop(done_pop)
  );

  isc_status_reg #(
    .ACK_CLEARABLE(ACK_CLEARABLE), .RESET_VALUE(RESET_VALUE),
    .RX_BIT(RX_BIT), .DONE_BIT(DONE_BIT), .TXE_BIT(TXE_BIT)
  ) u_st (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .clr_bits(clr_bits),
    .ack_stb(ack_stb), .done_pop(done_pop), .txq_empty(txq_empty),
    .done_nonempty(done_nonempty), .rx_pop(rx_pop), .rx_more(rx_more),
    .status_q(status_q)
  );

  isc_mask_reg u_mk (
    .clk(clk), .rst_n(rst_n), .mask_stb(mask_stb), .wr_data(wr_data),
    .mask_q(mask_q)
  );

  isc_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q), .irq(irq)
  );

  assign rd_data = rd_sel ? mask_q : status_q;

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & mask_q)) |=> irq);

  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & mask_q)) |=> !irq);

  p_pop_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |-> (wr_en && !wr_sel));
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ev_set = '0;
  logic       txq_empty = 1'b0;
  logic       done_nonempty = 1'b0;
  logic       rx_pop = 1'b0;
  logic       rx_more = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       done_pop;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] m_st;
  logic [7:0] m_mk;
  logic       m_irq;

  always #5 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .txq_empty(txq_empty),
    .done_nonempty(done_nonempty), .rx_pop(rx_pop), .rx_more(rx_more),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .done_pop(done_pop), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit clearable(input int b);
    return (b == 1) || (b == 2) || (b == 4) || (b == 6) || (b == 7);
  endfunction

  task automatic check_regs(input string req);
    rd_sel = 1'b0; #1;
    chk({req, " status"}, rd_data, m_st);
    rd_sel = 1'b1; #1;
    chk({req, " mask R9"}, rd_data, m_mk);
    chk({req, " irq R10"}, irq, m_irq);
  endtask

  // One clock cycle of stimulus followed by a check against the model.
  task automatic cyc(input string req, input logic [7:0] ev,
                     input bit ack_en, input logic [7:0] ackv,
                     input bit mk_en, input logic [7:0] mkv,
                     input bit txe, input bit dne, input bit pop, input bit more);
    logic [7:0] nst;
    bit popping;
    @(negedge clk);
    ev_set = ev; txq_empty = txe; done_nonempty = dne;
    rx_pop = pop; rx_more = more;
    wr_en = ack_en | mk_en; wr_sel = mk_en;
    wr_data = mk_en ? mkv : ackv;
    #1;
    popping = ack_en && ackv[1];
    chk({req, " done_pop R4"}, done_pop, popping);
    for (int b = 0; b < 8; b++) begin
      bit v;
      v = m_st[b];
      if (ack_en && ackv[b] && clearable(b)) v = 1'b0;
      if (b == 0 && pop) v = more;
      if (ev[b]) v = 1'b1;
      if (b == 2 && txe) v = 1'b1;
      if (b == 1 && dne && !popping) v = 1'b1;
      nst[b] = v;
    end
    @(posedge clk);
    m_irq = (m_st & m_mk) != 0;
    m_st = nst;
    if (mk_en) m_mk = mkv;
    #2;
    ev_set = '0; wr_en = 1'b0; rx_pop = 1'b0;
    check_regs(req);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_st = 8'h04; m_mk = 8'h00; m_irq = 1'b0;
    #1;
    check_regs("R1 reset");

    // R2: each event bit on its own, then clear the clearable ones
    for (int b = 0; b < 8; b++) begin
      cyc("R2 event", 8'(1 << b), 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R2 cleanup", 0, 1, 8'hFF, 0, 0, 0, 0, 0, 0);
    end

    // R3: every acknowledge value against a fully set status
    for (int v = 0; v < 256; v++) begin
      cyc("R3 preset", 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R3 ack", 0, 1, 8'(v), 0, 0, 0, 0, 0, 0);
    end

    // R5: transmit-empty cannot be acknowledged away while empty
    cyc("R5 empty", 0, 1, 8'h04, 0, 0, 1, 0, 0, 0);
    cyc("R5 ack held", 0, 1, 8'h04, 0, 0, 1, 0, 0, 0);
    cyc("R5 ack free", 0, 1, 8'h04, 0, 0, 0, 0, 0, 0);

    // R6: done bit with pop while queue reported non-empty
    cyc("R6 level", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R6 pop", 0, 1, 8'h02, 0, 0, 0, 1, 0, 0);
    cyc("R6 reassert", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R6 last pop", 0, 1, 8'h02, 0, 0, 0, 1, 0, 0);
    cyc("R6 stays clear", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4 pop with empty queue", 0, 1, 8'h02, 0, 0, 0, 0, 0, 0);

    // R7: receive pop reloads the receive bit
    cyc("R7 store", 8'h01, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7 pop more", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R7 pop last", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R7 pop idle", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R7 pop drain", 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R8: event wins over clear and pop in the same cycle
    cyc("R8 ev vs ack", 8'hFF, 1, 8'hFF, 0, 0, 0, 0, 0, 0);
    cyc("R8 ev vs pop", 8'h01, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R8 ack only", 0, 1, 8'hFF, 0, 0, 0, 0, 0, 0);

    // R9, R10: every mask value against a changing status
    for (int m = 0; m < 256; m++) begin
      cyc("R10 clear", 0, 1, 8'hFF, 0, 0, 0, 0, 1, 0);
      cyc("R9 mask", 8'((m * 37) & 8'hD6), 0, 0, 1, 8'(m), 0, 0, 0, 0);
      cyc("R10 settle", 0, 0, 0, 0, 0, m[0], 0, 0, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule